// File: doc/BRIEF.md
# Pulse-Counting Current-Mode PWM Modulator

This block drives the power switch of a step-down converter using current-mode control. It does not take samples from an A/D converter. An external voltage-to-frequency converter turns the amplified inductor-current signal into a pulse train, and the block counts those pulses. The block sees the pulses as a one-cycle strobe in its own clock domain. A free-running period timer marks the start of each switching period. At that point the switch is turned on and both pulse counters restart from zero.

One counter collects strobes while the switch is on and the other collects strobes while it is off. Their saturating sum is compared with an unsigned current reference. The switch is released in the first cycle in which the registered sum has reached the reference, and it stays off until the next period start. At every period start the block captures the total strobe count of the period that just ended. That total is proportional to the average inductor current, and the block presents it on a status output with a one-cycle valid flag. An outer voltage loop would supply the reference and could use this status value.

Top module: `pcm_current_modulator`

## Requirements
- R1: The period timer raises `cyc_start_o` for exactly one cycle every `PERIOD_CLKS` cycles. The first such cycle is the `PERIOD_CLKS`-th cycle after reset is released.
- R2: The switch output can only rise in the cycle right after a `cyc_start_o` cycle. It does rise there whenever the reference sampled at that period start is non-zero.
- R3: Each strobe is counted exactly once. It goes to the on-counter when `sw_o` is high in its cycle and to the off-counter otherwise. While `sw_o` is low the on-counter does not advance.
- R4: `sw_o` goes low in the first cycle in which the registered sum of both counters is greater than or equal to `iref_i`. It then stays low until the next period start.
- R5: A reference of zero keeps `sw_o` low for the whole period.
- R6: If the sum never reaches the reference, `sw_o` is forced low in the last cycle of the period (the `cyc_start_o` cycle). The switch is therefore high for at most `PERIOD_CLKS`-1 cycles per period.
- R7: Both counters are cleared at each period start. A strobe arriving in the `cyc_start_o` cycle still counts toward the period that is ending.
- R8: In the cycle after `cyc_start_o`, `avg_valid_o` is high for one cycle and `avg_o` holds the number of strobes seen in the `PERIOD_CLKS` cycles of the period that ended. `avg_o` keeps that value until the next capture.
- R9: Counters, sum and captured total saturate at 2^`CNT_W`-1 and never wrap.
- R10: While the synchronous reset `rst_i` is high, the counters, the captured total and the valid flag are cleared and the switch is held low. After reset the timer restarts, and the switch stays low until the first period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| vco_strobe_i | input | 1 | One-cycle strobe per converter pulse |
| iref_i | input | CNT_W | Current reference, unsigned pulse count |
| sw_o | output | 1 | Power switch drive, high = on |
| cyc_start_o | output | 1 | High in the last cycle of each switching period |
| avg_o | output | CNT_W | Captured strobe total of the previous period |
| avg_valid_o | output | 1 | One-cycle flag when `avg_o` has just been updated |

## Verification
The bench uses a short period and narrow counters so that every boundary can be reached:

- **Zero reference.** It applies a reference of zero. A design that sets the latch without looking at the reference would turn the switch on for one cycle or more.
- **Unreachable reference.** It runs a period whose pulse count can never reach the reference. The measured on-time must then be exactly one cycle short of the period; an off-by-one in the forced turn-off would show a full-length or shortened pulse.
- **Strobe in the last cycle.** It places a lone strobe in the period-start cycle. That strobe must appear in the captured total, so a design that clears the counters before adding that cycle's strobe would report zero.
- **Saturation.** It drives more strobes than the counter width can hold. A wrapping adder would then report a small total and let the switch turn back on. The run ends with a reset in mid-run, after which the captured total must be zero and the first period start must come a full period later.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
   // Default system clock is 100 MHz and switching period 40 us.
   localparam int unsigned DEF_PERIOD_CLKS = 4000;
   localparam int unsigned DEF_CNT_W       = 16;
   localparam int unsigned NUM_SIDES       = 2;

   // Index of each counter in the counter pair.
   typedef enum logic {
      SIDE_ON  = 1'b0,
      SIDE_OFF = 1'b1
   } side_e;
endpackage

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
   parameter int unsigned PERIOD_CLKS = pcm_pkg::DEF_PERIOD_CLKS
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic tick_o,      // last cycle of the period
   output logic pre_tick_o   // cycle before the last one
);
   localparam int unsigned TW = (PERIOD_CLKS > 2) ? $clog2(PERIOD_CLKS) : 2;
   localparam logic [TW-1:0] LAST = TW'(PERIOD_CLKS - 1);
   localparam logic [TW-1:0] PRE  = TW'(PERIOD_CLKS - 2);

   generate
      if (PERIOD_CLKS < 3) begin : g_bad_period
         $error("pcm_period_timer: PERIOD_CLKS must be at least 3");
      end
   endgenerate

   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)             tmr_q <= '0;
      else if (tmr_q == LAST) tmr_q <= '0;
      else                    tmr_q <= tmr_q + 1'b1;
   end

   assign tick_o     = (tmr_q == LAST);
   assign pre_tick_o = (tmr_q == PRE);

   // R1: the count wraps to zero right after the terminal cycle
   a_r1_wrap_after_tick: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_o |=> (tmr_q == '0));
   // R1: the timer never leaves its range
   a_r1_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
      tmr_q <= LAST);
endmodule

// File: rtl/pcm_pulse_counter.sv
module pcm_pulse_counter #(
   parameter int unsigned CNT_W = pcm_pkg::DEF_CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             clr_i,   // restart at period start
   input  logic             inc_i,   // strobe routed to this side
   output logic [CNT_W-1:0] cnt_o,   // registered count
   output logic [CNT_W-1:0] adv_o    // count including this cycle's strobe
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pcm_pulse_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   // saturating advance
   assign adv_o = (inc_i && (cnt_q != CMAX)) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) cnt_q <= '0;
      else                cnt_q <= adv_o;
   end

   assign cnt_o = cnt_q;

   // R7: a clear empties the counter
   a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i |=> (cnt_q == '0));
   // R9: without a clear the counter never goes down (no wrap)
   a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
      !clr_i |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/pcm_sat_adder.sv
module pcm_sat_adder #(
   parameter int unsigned CNT_W = pcm_pkg::DEF_CNT_W
) (
   input  logic [CNT_W-1:0] a_i,
   input  logic [CNT_W-1:0] b_i,
   output logic [CNT_W-1:0] sum_o
);
   logic [CNT_W:0] full;

   assign full  = {1'b0, a_i} + {1'b0, b_i};
   assign sum_o = full[CNT_W] ? {CNT_W{1'b1}} : full[CNT_W-1:0];

   // R9: the sum is never smaller than either operand
   always_comb begin
      a_r9_sum_no_wrap: assert ((sum_o >= a_i) && (sum_o >= b_i));
   end
endmodule

// File: rtl/pcm_switch_latch.sv
module pcm_switch_latch #(
   parameter int unsigned CNT_W = pcm_pkg::DEF_CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,      // period start: set
   input  logic             pre_tick_i,  // force off for the last cycle
   input  logic [CNT_W-1:0] sum_i,       // registered counter sum
   input  logic [CNT_W-1:0] ref_i,
   output logic             sw_o
);
   logic set_q;
   logic reached;

   assign reached = (sum_i >= ref_i);
   // release takes effect in the same cycle the compare becomes true
   assign sw_o    = set_q && !reached;

   always_ff @(posedge clk_i) begin
      if (rst_i)                   set_q <= 1'b0;
      else if (tick_i)             set_q <= (ref_i != '0);
      else if (!sw_o || pre_tick_i) set_q <= 1'b0;
   end

   // R2: the switch only turns on straight after a period start
   a_r2_rise_after_tick: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(sw_o) |-> $past(tick_i));
   // R4: once released the switch stays off until the next period start
   a_r4_hold_off: assert property (@(posedge clk_i) disable iff (rst_i)
      (!sw_o && !tick_i) |=> !sw_o);
   // R6: the last cycle of the period is always off
   a_r6_off_at_tick: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_i |-> !sw_o);
   // R5: a zero reference at the period start keeps the switch off
   a_r5_zero_ref: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_i && (ref_i == '0)) |=> !sw_o);
endmodule

// File: rtl/pcm_current_modulator.sv
module pcm_current_modulator #(
   parameter int unsigned PERIOD_CLKS = pcm_pkg::DEF_PERIOD_CLKS,
   parameter int unsigned CNT_W       = pcm_pkg::DEF_CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             vco_strobe_i,
   input  logic [CNT_W-1:0] iref_i,
   output logic             sw_o,
   output logic             cyc_start_o,
   output logic [CNT_W-1:0] avg_o,
   output logic             avg_valid_o
);
   import pcm_pkg::*;

   logic             tick;
   logic             pre_tick;
   logic             sw;
   logic [CNT_W-1:0] cnt [NUM_SIDES];
   logic [CNT_W-1:0] adv [NUM_SIDES];
   logic [CNT_W-1:0] sum_now;
   logic [CNT_W-1:0] sum_adv;
   logic [CNT_W-1:0] avg_q;
   logic             vld_q;

   pcm_period_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .tick_o     (tick),
      .pre_tick_o (pre_tick)
   );

   // one counter per switch state, both fed from the same strobe
   for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
      logic route;
      if (g == int'(SIDE_ON)) begin : g_on
         assign route = vco_strobe_i && sw;
      end else begin : g_off
         assign route = vco_strobe_i && !sw;
      end
      pcm_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .clr_i (tick),
         .inc_i (route),
         .cnt_o (cnt[g]),
         .adv_o (adv[g])
      );
   end

   pcm_sat_adder #(.CNT_W(CNT_W)) u_sum_now (
      .a_i   (cnt[SIDE_ON]),
      .b_i   (cnt[SIDE_OFF]),
      .sum_o (sum_now)
   );

   pcm_sat_adder #(.CNT_W(CNT_W)) u_sum_adv (
      .a_i   (adv[SIDE_ON]),
      .b_i   (adv[SIDE_OFF]),
      .sum_o (sum_adv)
   );

   pcm_switch_latch #(.CNT_W(CNT_W)) u_latch (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .tick_i     (tick),
      .pre_tick_i (pre_tick),
      .sum_i      (sum_now),
      .ref_i      (iref_i),
      .sw_o       (sw)
   );

   // capture the period total, including the strobe of the final cycle
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         avg_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= tick;
         if (tick) avg_q <= sum_adv;
      end
   end

   assign sw_o        = sw;
   assign cyc_start_o = tick;
   assign avg_o       = avg_q;
   assign avg_valid_o = vld_q;

   // R3: the on-side counter is frozen while the switch is off
   a_r3_on_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
      (!sw && !tick) |=> (cnt[SIDE_ON] == $past(cnt[SIDE_ON])));
   // R3: the off-side counter is frozen while the switch is on
   a_r3_off_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
      (sw && !tick) |=> (cnt[SIDE_OFF] == $past(cnt[SIDE_OFF])));
   // R8: the valid flag follows a period start
   a_r8_valid_after_tick: assert property (@(posedge clk_i) disable iff (rst_i)
      avg_valid_o |-> $past(tick));
   // R8: the captured total holds between captures
   a_r8_avg_stable: assert property (@(posedge clk_i) disable iff (rst_i)
      !tick |=> $stable(avg_o));
   // R10: the cycle after a reset shows the switch off and the total cleared
   a_r10_reset_state: assert property (@(posedge clk_i)
      $past(rst_i) |-> (!sw_o && (avg_o == '0) && !avg_valid_o));
endmodule

// File: tb/pcm_current_modulator_test.sv
module pcm_current_modulator_test;
   localparam int P    = 80;
   localparam int W    = 6;
   localparam int MAXC = (1 << W) - 1;

   typedef struct {
      int on_cycles;
      int total;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         strb = 1'b0;
   logic [W-1:0] iref = '0;
   logic         sw;
   logic         cstart;
   logic [W-1:0] avg;
   logic         avg_vld;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit mon_en = 1'b0;
   exp_t sb[$];
   int cur_ref = 0;

   always #5 clk = ~clk;

   pcm_current_modulator #(.PERIOD_CLKS(P), .CNT_W(W)) uut (
      .clk_i        (clk),
      .rst_i        (rst),
      .vco_strobe_i (strb),
      .iref_i       (iref),
      .sw_o         (sw),
      .cyc_start_o  (cstart),
      .avg_o        (avg),
      .avg_valid_o  (avg_vld)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Driver: entered at the negedge of the first cycle of a period.
   // mode 0 none, 1 all, 2 every arg-th cycle, 3 first arg cycles, 4 last cycle only
   task automatic run_period(input int mode, input int arg, input int nref, input bit warm);
      bit   pat [P];
      exp_t e;
      int   s, tot;
      bit   on;
      for (int j = 0; j < P; j++) begin
         case (mode)
            1: pat[j] = 1'b1;
            2: pat[j] = ((j % arg) == 0);
            3: pat[j] = (j < arg);
            4: pat[j] = (j == P - 1);
            default: pat[j] = 1'b0;
         endcase
      end
      // R4/R5/R6: on while registered sum < ref, never in the last cycle
      s = 0; on = !warm; e.on_cycles = 0;
      for (int j = 0; j < P - 1; j++) begin
         if (on && (s < cur_ref)) e.on_cycles++;
         else on = 1'b0;
         if (pat[j] && s < MAXC) s++;
      end
      // R7/R8/R9: total over all P cycles, saturated
      tot = 0;
      for (int j = 0; j < P; j++) if (pat[j] && tot < MAXC) tot++;
      e.total = tot;
      sb.push_back(e);
      for (int j = 0; j < P; j++) begin
         strb = pat[j];
         if (j == P - 1) iref = W'(nref);
         @(negedge clk);
      end
      strb = 1'b0;
      cur_ref = nref;
   endtask

   // Monitor: measures on-time per period and checks the captured total
   initial begin
      int   hi = 0;
      bit   pend = 1'b0;
      exp_t e;
      e.on_cycles = 0;
      e.total = 0;
      forever begin
         @(negedge clk);
         if (mon_en) begin
            if (pend) begin
               check(avg_vld == 1'b1, "R8 valid flag", int'(avg_vld), 1);
               check(int'(avg) == e.total, "R8/R9/R7 period total", int'(avg), e.total);
               pend = 1'b0;
            end
            if (sw) hi++;
            if (cstart) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R1 unexpected period start", 1, 0);
               end else begin
                  e = sb.pop_front();
                  check(hi == e.on_cycles, "R2/R4/R5/R6 on-time", hi, e.on_cycles);
                  pend = 1'b1;
               end
               hi = 0;
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: state held in reset
      check(sw == 1'b0, "R10 switch in reset", int'(sw), 0);
      check(avg == '0, "R10 total in reset", int'(avg), 0);
      check(avg_vld == 1'b0, "R10 valid in reset", int'(avg_vld), 0);
      rst = 1'b0;
      mon_en = 1'b1;
      run_period(0, 0, 20, 1'b1);  // R10: first period off
      run_period(2, 2, 10, 1'b0);  // R4: every other cycle, ref 20
      run_period(1, 0, 0, 1'b0);   // R4/R9: dense, ref 10, total saturates
      run_period(1, 0, 50, 1'b0);  // R5: ref 0 with strobes
      run_period(2, 4, 63, 1'b0);  // R6: ref 50 never reached
      run_period(0, 0, 5, 1'b0);   // R6: no strobes, ref 63
      run_period(3, 5, 1, 1'b0);   // R3/R4: burst of 5, ref 5
      run_period(4, 0, 63, 1'b0);  // R7: lone strobe in last cycle, ref 1
      run_period(1, 0, 0, 1'b0);   // R9: ref at full scale with saturating sum
      @(negedge clk);
      mon_en = 1'b0;
      check(sb.size() == 0, "R1 all periods observed", sb.size(), 0);
      // R10: reset in mid-run clears state and restarts the timer
      iref = W'(30);
      strb = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      check(avg == '0, "R10 total cleared", int'(avg), 0);
      check(sw == 1'b0, "R10 switch cleared", int'(sw), 0);
      rst = 1'b0;
      begin
         int first = -1;
         bit sw_seen = 1'b0;
         for (int k = 0; k < 2 * P; k++) begin
            if (sw && first < 0) sw_seen = 1'b1;
            if (cstart && first < 0) first = k;
            @(negedge clk);
         end
         check(first == P - 1, "R1 first period start after reset", first, P - 1);
         check(!sw_seen, "R10 switch off before first period start", int'(sw_seen), 0);
      end
      strb = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule